// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the time of day for a precision time protocol clock. It holds a nanosecond count that wraps once a second and a seconds count. The seconds count is split into a 32-bit low word and a narrower high word. On every clock edge the count moves forward by a programmable step. The step has an integer nanosecond part and a 24-bit fraction of a nanosecond, and a fractional accumulator turns the fraction into an occasional extra nanosecond.

Software works on the counter through a small word-wide register port. Register addresses: 0 nanoseconds, 1 seconds low, 2 seconds high, 3 integer step, 4 fractional step, 5 one-shot adjust.
- A fraction written to address 4 waits in a staging register. It takes effect when address 3 is written.
- A write to address 5 moves the time once by a signed offset smaller than one second.
- Reading address 0 freezes a copy of the seconds. Later reads of addresses 1 and 2 therefore belong to the same instant as the nanosecond value just read.

To set the full time, software writes, in order: nanoseconds to zero, seconds high, seconds low, then nanoseconds.

Top module: `tod_counter`

## Requirements
- R1: After reset the nanosecond, seconds, integer step and fractional step registers all read zero, and the counter does not advance.
- R2: Each edge, nanoseconds grow by the integer step plus one when the 24-bit fractional accumulator overflows. After a step commit, k edges add k*I + floor(k*F / 2^24).
- R3: At address 4, fraction bits [23:8] travel in data bits [15:0] and fraction bits [7:0] travel in data bits [31:24]. Reading address 4 returns the active fraction in the same layout, with bits [23:16] zero.
- R4: A write to address 4 changes nothing in the active step. The staged fraction becomes active, and the accumulator restarts from zero, on the edge of the next write to address 3.
- R5: When nanoseconds reach 1,000,000,000 they wrap to the remainder and the seconds increment. A carry out of the low seconds word goes into the high word. Nanoseconds never read 1,000,000,000 or more.
- R6: A write to address 0, 1 or 2 loads that field on the write edge in place of its advance. A write to the high word changes only the high word. Nanosecond writes must be below one second.
- R7: On address 5, bit 31 = 0 means add and bits [29:0] hold the magnitude. The offset is applied on the write edge only, on top of that edge's step. A result past one second carries into the seconds.
- R8: On address 5 with bit 31 = 1, the magnitude is subtracted. If the result is below zero it borrows one second, across the word boundary when needed.
- R9: Reading address 0 copies the seconds on that edge into a shadow. Addresses 1 and 2 return the shadow until the next read of address 0.
- R10: With integer and fractional steps both zero and no writes, nanoseconds and seconds hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, one register per cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; used for the snapshot side effect |
| rd_data | output | 32 | Read data for reg_addr, combinational |

## Verification
The step and the one-shot adjust both act on the same edge: the adjusted result must include that edge's step, and a wrap or borrow can follow from the combined sum. The bench provokes this by writing the adjust register while the counter runs at 4 ns per edge. It does so for a plain add, an add that crosses one second, a subtract that borrows across the seconds word boundary, and a subtract that does not borrow. Each case is judged against the starting value plus the step plus or minus the magnitude, with the seconds read back through the snapshot path.

// File: rtl/tod_pkg.sv
// Shared register addresses and adjust-word fields for the time-of-day counter.
// Assumes a 32-bit register port.
package tod_pkg;
    typedef enum logic [2:0] {
        TA_NSEC  = 3'd0,
        TA_SECLO = 3'd1,
        TA_SECHI = 3'd2,
        TA_INCNS = 3'd3,
        TA_INCFR = 3'd4,
        TA_ADJ   = 3'd5
    } tod_addr_e;

    localparam int REG_W     = 32;
    localparam int ADJ_SUB_B = 31;
    localparam int ADJ_MAG_W = 30;
endpackage

// File: rtl/tod_step.sv
// Fractional accumulator: turns integer + fractional step into a per-edge ns step.
// Assumes restart pulses on the edge that commits a new step pair.
module tod_step #(
    parameter int INC_NS_W = 8,
    parameter int FRAC_W   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [INC_NS_W-1:0] inc_ns,
    input  logic [FRAC_W-1:0]   frac,
    output logic [INC_NS_W:0]   step
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_sum;
    logic              carry;

    // Add the fraction and derive this edge's step including the overflow carry.
    always_comb begin
        {carry, acc_sum} = {1'b0, acc_q} + {1'b0, frac};
        step = {1'b0, inc_ns} + {{INC_NS_W{1'b0}}, carry};
    end

    // Hold the fraction remainder; clear it when a new step is committed.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (restart) acc_q <= '0;
        else              acc_q <= acc_sum;
    end
endmodule

// File: rtl/tod_time.sv
// Nanosecond and seconds state with wrap, one-shot signed adjust and direct loads.
// Assumes adjust magnitude below one second and loaded ns values below one second.
module tod_time #(
    parameter int NS_W       = 30,
    parameter int SECHI_W    = 16,
    parameter int INC_NS_W   = 8,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [INC_NS_W:0]          step,
    input  logic                       ns_wr,
    input  logic                       lo_wr,
    input  logic                       hi_wr,
    input  logic [31:0]                wr_data,
    input  logic                       adj_wr,
    input  logic                       adj_sub,
    input  logic [tod_pkg::ADJ_MAG_W-1:0] adj_mag,
    output logic [NS_W-1:0]            ns_q,
    output logic [32+SECHI_W-1:0]      sec_q
);
    localparam int SEC_W = 32 + SECHI_W;
    localparam int T_W   = NS_W + 3;
    localparam logic signed [T_W-1:0] NSPS = T_W'(NS_PER_SEC);

    logic signed [T_W-1:0] t_raw, t_fix;
    logic [SEC_W-1:0]      sec_adv;
    logic [NS_W-1:0]       ns_nxt;

    // Sum step and optional signed offset, then fold into one second.
    always_comb begin
        t_raw = $signed({3'b000, ns_q})
              + $signed({{(T_W-INC_NS_W-1){1'b0}}, step});
        if (adj_wr) begin
            if (adj_sub) t_raw = t_raw - $signed({3'b000, adj_mag});
            else         t_raw = t_raw + $signed({3'b000, adj_mag});
        end
        if (t_raw < 0) begin
            t_fix   = t_raw + NSPS;
            sec_adv = sec_q - 1'b1;
        end else if (t_raw >= NSPS) begin
            t_fix   = t_raw - NSPS;
            sec_adv = sec_q + 1'b1;
        end else begin
            t_fix   = t_raw;
            sec_adv = sec_q;
        end
        ns_nxt = t_fix[NS_W-1:0];
    end

    // Register the time; direct register writes override the advance per field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q  <= '0;
            sec_q <= '0;
        end else begin
            ns_q              <= ns_wr ? wr_data[NS_W-1:0] : ns_nxt;
            sec_q[31:0]       <= lo_wr ? wr_data : sec_adv[31:0];
            sec_q[SEC_W-1:32] <= hi_wr ? wr_data[SECHI_W-1:0] : sec_adv[SEC_W-1:32];
        end
    end

    // R5
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ns_q < NS_W'(NS_PER_SEC));

    // R10
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0 && !ns_wr && !lo_wr && !hi_wr && !adj_wr)
        |=> ($stable(ns_q) && $stable(sec_q)));

    // R5
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ns_wr && !lo_wr && !hi_wr && !adj_wr)
        |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));
endmodule

// File: rtl/tod_regs.sv
// Register decode: step registers with staged fraction, adjust decode, read mux and
// seconds shadow. Assumes at most one register access per cycle on reg_addr.
module tod_regs #(
    parameter int NS_W     = 30,
    parameter int SECHI_W  = 16,
    parameter int INC_NS_W = 8,
    parameter int FRAC_W   = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 reg_addr,
    input  logic                       wr_en,
    input  logic [31:0]                wr_data,
    input  logic                       rd_en,
    input  logic [NS_W-1:0]            ns_q,
    input  logic [32+SECHI_W-1:0]      sec_q,
    output logic [31:0]                rd_data,
    output logic [INC_NS_W-1:0]        inc_ns,
    output logic [FRAC_W-1:0]          frac_act,
    output logic                       commit,
    output logic                       ns_wr,
    output logic                       lo_wr,
    output logic                       hi_wr,
    output logic                       adj_wr,
    output logic                       adj_sub,
    output logic [tod_pkg::ADJ_MAG_W-1:0] adj_mag
);
    import tod_pkg::*;
    localparam int SEC_W     = 32 + SECHI_W;
    localparam int FRAC_HI_W = FRAC_W - 8;
    localparam int GAP_W     = 32 - FRAC_W;

    logic [FRAC_W-1:0] frac_stage_q;
    logic [FRAC_W-1:0] frac_in;
    logic [SEC_W-1:0]  shadow_q;
    logic              frac_wr;
    logic              snap;

    // Decode write strobes and unpack the split fraction layout.
    always_comb begin
        ns_wr   = wr_en && reg_addr == TA_NSEC;
        lo_wr   = wr_en && reg_addr == TA_SECLO;
        hi_wr   = wr_en && reg_addr == TA_SECHI;
        commit  = wr_en && reg_addr == TA_INCNS;
        frac_wr = wr_en && reg_addr == TA_INCFR;
        adj_wr  = wr_en && reg_addr == TA_ADJ;
        adj_sub = wr_data[ADJ_SUB_B];
        adj_mag = wr_data[ADJ_MAG_W-1:0];
        snap    = rd_en && reg_addr == TA_NSEC;
        frac_in = {wr_data[FRAC_HI_W-1:0], wr_data[31:24]};
    end

    // Hold the step pair; the staged fraction moves to active on an integer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_ns       <= '0;
            frac_stage_q <= '0;
            frac_act     <= '0;
        end else begin
            if (frac_wr) frac_stage_q <= frac_in;
            if (commit) begin
                inc_ns   <= wr_data[INC_NS_W-1:0];
                frac_act <= frac_stage_q;
            end
        end
    end

    // Capture the seconds whenever the nanosecond register is read.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (snap) shadow_q <= sec_q;
    end

    // Select read data for the addressed register.
    always_comb begin
        case (reg_addr)
            TA_NSEC:  rd_data = {{(32-NS_W){1'b0}}, ns_q};
            TA_SECLO: rd_data = shadow_q[31:0];
            TA_SECHI: rd_data = {{(64-SEC_W){1'b0}}, shadow_q[SEC_W-1:32]};
            TA_INCNS: rd_data = {{(32-INC_NS_W){1'b0}}, inc_ns};
            TA_INCFR: rd_data = {frac_act[7:0], {GAP_W{1'b0}}, frac_act[FRAC_W-1:8]};
            default:  rd_data = '0;
        endcase
    end

    // R4
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frac_wr |=> $stable(frac_act));

    // R9
    snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (shadow_q == $past(sec_q)));
endmodule

// File: rtl/tod_counter.sv
// Top of the time-of-day counter: wires register decode, step accumulator and time state.
// Assumes software uses the documented time-set order; the high word never latches.
module tod_counter #(
    parameter int NS_W       = 30,
    parameter int SECHI_W    = 16,
    parameter int INC_NS_W   = 8,
    parameter int FRAC_W     = 24,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data
);
    localparam int SEC_W = 32 + SECHI_W;

    logic [NS_W-1:0]     ns_q;
    logic [SEC_W-1:0]    sec_q;
    logic [INC_NS_W-1:0] inc_ns;
    logic [FRAC_W-1:0]   frac_act;
    logic [INC_NS_W:0]   step;
    logic                commit, ns_wr, lo_wr, hi_wr, adj_wr, adj_sub;
    logic [tod_pkg::ADJ_MAG_W-1:0] adj_mag;

    tod_regs #(.NS_W(NS_W), .SECHI_W(SECHI_W), .INC_NS_W(INC_NS_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .ns_q(ns_q), .sec_q(sec_q), .rd_data(rd_data), .inc_ns(inc_ns),
        .frac_act(frac_act), .commit(commit), .ns_wr(ns_wr), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .adj_wr(adj_wr), .adj_sub(adj_sub), .adj_mag(adj_mag)
    );

    tod_step #(.INC_NS_W(INC_NS_W), .FRAC_W(FRAC_W)) u_step (
        .clk(clk), .rst_n(rst_n), .restart(commit), .inc_ns(inc_ns), .frac(frac_act),
        .step(step)
    );

    tod_time #(.NS_W(NS_W), .SECHI_W(SECHI_W), .INC_NS_W(INC_NS_W),
               .NS_PER_SEC(NS_PER_SEC)) u_time (
        .clk(clk), .rst_n(rst_n), .step(step), .ns_wr(ns_wr), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .wr_data(wr_data), .adj_wr(adj_wr), .adj_sub(adj_sub), .adj_mag(adj_mag),
        .ns_q(ns_q), .sec_q(sec_q)
    );
endmodule

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
module sim_tod_counter;
    localparam longint NSPS = 1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    int          errs = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    tod_counter u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
                    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

    // Every task starts and ends at a falling edge and spans one rising edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [31:0] pack_frac(input logic [23:0] f);
        return {f[7:0], 8'h00, f[23:8]};
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v1;
        logic [23:0] fl [5];
        logic [7:0]  il [4];
        int          kl [4];
        fl = '{24'h000000, 24'h000001, 24'h800000, 24'h555555, 24'hFFFFFF};
        il = '{8'd0, 8'd1, 8'd7, 8'd255};
        kl = '{0, 1, 5, 37};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and no advance
        rd(3'd0, v); chk("R1 ns", v, 0);
        rd(3'd1, v); chk("R1 sec lo", v, 0);
        rd(3'd2, v); chk("R1 sec hi", v, 0);
        rd(3'd3, v); chk("R1 int step", v, 0);
        rd(3'd4, v); chk("R1 frac step", v, 0);
        repeat (10) @(negedge clk);
        rd(3'd0, v); chk("R1 held", v, 0);

        // R4 staging, R3 layout
        wr(3'd4, 32'hAB00_1234);
        rd(3'd4, v); chk("R4 staged not active", v, 0);
        wr(3'd3, 32'd3);
        rd(3'd4, v); chk("R3 frac readback", v, 32'hAB00_1234);
        rd(3'd3, v); chk("R4 int step", v, 3);

        // R2 sweep over step pairs and elapsed edges
        foreach (il[i]) foreach (fl[j]) foreach (kl[n]) begin
            longint exp_ns;
            wr(3'd4, 0); wr(3'd3, 0);
            wr(3'd0, 1000);
            wr(3'd4, pack_frac(fl[j]));
            wr(3'd3, {24'h0, il[i]});
            repeat (kl[n]) @(negedge clk);
            rd(3'd0, v);
            exp_ns = 1000 + longint'(kl[n]) * il[i] + ((longint'(kl[n]) * fl[j]) >> 24);
            chk("R2 step sweep", v, exp_ns[31:0]);
        end

        // R5 wrap with carry into high word
        wr(3'd4, 0); wr(3'd3, 0);
        wr(3'd2, 1); wr(3'd1, 32'hFFFF_FFFF); wr(3'd0, NSPS - 10);
        wr(3'd4, 0); wr(3'd3, 4);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R5 ns wrap", v, 2);
        rd(3'd1, v); chk("R5 sec lo carry", v, 0);
        rd(3'd2, v); chk("R5 sec hi carry", v, 2);

        // R9 shadow holds across a wrap
        wr(3'd0, NSPS - 20);
        rd(3'd0, v); chk("R9 ns sample", v, NSPS - 20);
        repeat (10) @(negedge clk);
        rd(3'd1, v); chk("R9 shadow held", v, 0);
        rd(3'd0, v);
        rd(3'd1, v); chk("R9 shadow refreshed", v, 1);

        // R6 high word write alone
        wr(3'd2, 32'h1234);
        rd(3'd0, v);
        rd(3'd2, v); chk("R6 sec hi load", v, 32'h1234);
        rd(3'd1, v); chk("R6 sec lo untouched", v, 1);

        // R7 add adjust, coincident with a 4 ns step
        wr(3'd2, 0); wr(3'd1, 50);
        wr(3'd0, 100); wr(3'd5, 500);
        rd(3'd0, v); chk("R7 add", v, 604);
        wr(3'd0, NSPS - 1000); wr(3'd5, 2000);
        rd(3'd0, v); chk("R7 add carry ns", v, 1004);
        rd(3'd1, v); chk("R7 add carry sec", v, 51);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R7 applied once", v, 1024);

        // R8 subtract with borrow across the word boundary, then without
        wr(3'd2, 2); wr(3'd1, 0);
        wr(3'd0, 300); wr(3'd5, 32'h8000_0000 | 1000);
        rd(3'd0, v); chk("R8 borrow ns", v, NSPS - 696);
        rd(3'd1, v); chk("R8 borrow sec lo", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R8 borrow sec hi", v, 1);
        wr(3'd0, 5000); wr(3'd5, 32'h8000_0000 | 1000);
        rd(3'd0, v); chk("R8 sub no borrow", v, 4004);

        // R10 zero step freezes the time
        wr(3'd4, 0); wr(3'd3, 0);
        rd(3'd0, v1);
        repeat (20) @(negedge clk);
        rd(3'd0, v); chk("R10 ns frozen", v, v1);
        rd(3'd1, v); chk("R10 sec frozen", v, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule